// File: doc/BRIEF.md
# VLIW Molecule Slot Dispatcher

This block takes one instruction bundle per clock. A bundle is called a molecule. It holds up to four operations, called atoms. Each atom carries a valid bit, a 3-bit slot type and an opcode/operand field. The dispatcher sends every valid atom to a functional unit of the matching kind. The fixed set of units is two integer ALUs, one floating-point unit, one load/store unit and one branch unit. An immediate atom occupies no unit. It lends its constant to the atom in the slot just before it, and that constant travels with that atom to its unit.

The block does not split a bundle that asks for more units than exist. It rejects the whole bundle instead: it raises a malformed-molecule flag, drives every unit idle and reports an issue count of zero. It treats orphaned immediates and undefined type codes the same way. All outputs are registered, so unit valids appear one clock after the molecule is presented.

Top module: `molecule_dispatch`

## Requirements
- R1: Outputs are registered. A molecule presented before a rising edge appears at the outputs after that edge and not before it. A synchronous active-high reset drives every output to zero.
- R2: Slot type codes are 0 = integer ALU, 1 = floating point, 2 = load/store, 3 = branch and 4 = immediate. A valid atom with code 5, 6 or 7 makes the molecule malformed.
- R3: Integer ALU atoms fill ALU unit 0 first and then ALU unit 1, in increasing atom index. A third ALU atom in one molecule makes it malformed.
- R4: A floating-point, load/store or branch atom goes to the single unit of its kind. A second atom of any of these kinds in one molecule makes it malformed.
- R5: A valid immediate atom at index i attaches its field to the atom at index i-1. The unit that receives that atom shows its immediate-valid bit set and the constant. The immediate uses no unit and is not counted.
- R6: A valid immediate atom at index 0, or one whose index i-1 atom is invalid or is itself an immediate, makes the molecule malformed.
- R7: For a malformed molecule the flag is 1, the issue count is 0, and every unit valid and immediate-valid bit is 0.
- R8: The issue count equals the number of atoms routed to units. Invalid atoms have no effect, whatever their type and field bits.
- R9: The opcode field of a unit whose valid is low is zero. The immediate field of a unit whose immediate-valid is low is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| atom_vld | input | N_ATOMS | Per-atom valid bits, bit i for atom i |
| atom_type | input | 3*N_ATOMS | Slot type codes, atom i in bits [3i+2:3i] |
| atom_op | input | OPW*N_ATOMS | Opcode/operand fields, atom i in bits [OPW*i+OPW-1:OPW*i] |
| alu_vld | output | N_ALU | Integer ALU issue valids, bit k for unit k |
| alu_op | output | OPW*N_ALU | Field issued to each ALU, unit k in slice k |
| alu_imm_vld | output | N_ALU | Immediate attached for each ALU |
| alu_imm | output | OPW*N_ALU | Immediate constant for each ALU |
| fpu_vld | output | 1 | Floating-point unit issue valid |
| fpu_op | output | OPW | Floating-point unit field |
| fpu_imm_vld | output | 1 | Immediate attached for the FP unit |
| fpu_imm | output | OPW | Immediate constant for the FP unit |
| lsu_vld | output | 1 | Load/store unit issue valid |
| lsu_op | output | OPW | Load/store unit field |
| lsu_imm_vld | output | 1 | Immediate attached for the load/store unit |
| lsu_imm | output | OPW | Immediate constant for the load/store unit |
| bru_vld | output | 1 | Branch unit issue valid |
| bru_op | output | OPW | Branch unit field |
| bru_imm_vld | output | 1 | Immediate attached for the branch unit |
| bru_imm | output | OPW | Immediate constant for the branch unit |
| issue_cnt | output | clog2(N_ATOMS+1) | Number of atoms issued this cycle |
| bad_mol | output | 1 | Malformed molecule flag |

## Verification
The only internal state is the output register stage, so any routing fault shows at the ports one cycle after the molecule that causes it. A wrong occupancy decision shows in that cycle as a mismatch between the issue count and the number of raised unit valids. It can also show as an ALU-1 valid without ALU-0, an immediate flag on an idle unit, or a missing or spurious malformed flag. The bench sweeps every combination of invalid and type code over the four slots, with slot-dependent fields. A misrouted field or a stale immediate therefore shows up in the very next output cycle.

// File: rtl/mdisp_pkg.sv
package mdisp_pkg;
  localparam int TYPE_W = 3;

  typedef enum logic [TYPE_W-1:0] {
    SLOT_ALU = 3'd0,
    SLOT_FPU = 3'd1,
    SLOT_MEM = 3'd2,
    SLOT_BR  = 3'd3,
    SLOT_IMM = 3'd4
  } slot_e;

  // single-instance units handled as a small array in the router
  localparam int N_SOLO = 3;
  localparam int SOLO_FPU = 0;
  localparam int SOLO_MEM = 1;
  localparam int SOLO_BR  = 2;
endpackage

// File: rtl/mdisp_classify.sv
module mdisp_classify
  import mdisp_pkg::*;
#(
  parameter int N_ATOMS = 4
) (
  input  logic [N_ATOMS-1:0]        atom_vld,
  input  logic [N_ATOMS*TYPE_W-1:0] atom_type,
  output logic [N_ATOMS-1:0]        is_alu,
  output logic [N_ATOMS-1:0]        is_fpu,
  output logic [N_ATOMS-1:0]        is_mem,
  output logic [N_ATOMS-1:0]        is_br,
  output logic [N_ATOMS-1:0]        is_imm,
  output logic [N_ATOMS-1:0]        is_bad
);
  for (genvar i = 0; i < N_ATOMS; i++) begin : g_atom
    logic [TYPE_W-1:0] t;
    logic imm_here, illegal, orphan;
    assign t        = atom_type[i*TYPE_W +: TYPE_W];
    assign imm_here = atom_vld[i] && (t == SLOT_IMM);
    assign is_alu[i] = atom_vld[i] && (t == SLOT_ALU);
    assign is_fpu[i] = atom_vld[i] && (t == SLOT_FPU);
    assign is_mem[i] = atom_vld[i] && (t == SLOT_MEM);
    assign is_br[i]  = atom_vld[i] && (t == SLOT_BR);
    assign is_imm[i] = imm_here;
    assign illegal   = atom_vld[i] && (t > SLOT_IMM);
    if (i == 0) begin : g_first
      assign orphan = imm_here;
    end else begin : g_rest
      logic [TYPE_W-1:0] tp;
      assign tp     = atom_type[(i-1)*TYPE_W +: TYPE_W];
      assign orphan = imm_here && (!atom_vld[i-1] || (tp == SLOT_IMM));
    end
    assign is_bad[i] = illegal | orphan;
  end
endmodule

// File: rtl/mdisp_route.sv
module mdisp_route
  import mdisp_pkg::*;
#(
  parameter int N_ATOMS = 4,
  parameter int N_ALU   = 2,
  parameter int OPW     = 8,
  parameter int CW      = 3
) (
  input  logic [N_ATOMS-1:0]     is_alu,
  input  logic [N_ATOMS-1:0]     is_fpu,
  input  logic [N_ATOMS-1:0]     is_mem,
  input  logic [N_ATOMS-1:0]     is_br,
  input  logic [N_ATOMS-1:0]     is_imm,
  input  logic [N_ATOMS-1:0]     is_bad,
  input  logic [N_ATOMS*OPW-1:0] atom_op,
  output logic [N_ALU-1:0]       alu_v,
  output logic [N_ALU*OPW-1:0]   alu_o,
  output logic [N_ALU-1:0]       alu_iv,
  output logic [N_ALU*OPW-1:0]   alu_i,
  output logic [N_SOLO-1:0]      solo_v,
  output logic [N_SOLO*OPW-1:0]  solo_o,
  output logic [N_SOLO-1:0]      solo_iv,
  output logic [N_SOLO*OPW-1:0]  solo_i,
  output logic [CW-1:0]          cnt,
  output logic                   err
);
  logic [OPW-1:0]     op_a    [N_ATOMS];
  logic [N_ATOMS-1:0] nxt_iv;
  logic [OPW-1:0]     nxt_val [N_ATOMS];
  logic [N_ATOMS-1:0] sel     [N_SOLO];

  assign sel[SOLO_FPU] = is_fpu;
  assign sel[SOLO_MEM] = is_mem;
  assign sel[SOLO_BR]  = is_br;

  for (genvar i = 0; i < N_ATOMS; i++) begin : g_op
    assign op_a[i] = atom_op[i*OPW +: OPW];
    if (i < N_ATOMS-1) begin : g_nxt
      assign nxt_iv[i]  = is_imm[i+1];
      assign nxt_val[i] = is_imm[i+1] ? atom_op[(i+1)*OPW +: OPW] : '0;
    end else begin : g_last
      assign nxt_iv[i]  = 1'b0;
      assign nxt_val[i] = '0;
    end
  end

  logic [N_ALU-1:0]  av_r, aiv_r;
  logic [OPW-1:0]    ao_r [N_ALU];
  logic [OPW-1:0]    ai_r [N_ALU];
  logic [N_SOLO-1:0] sv_r, siv_r;
  logic [OPW-1:0]    so_r [N_SOLO];
  logic [OPW-1:0]    si_r [N_SOLO];
  logic [CW-1:0]     cnt_r;
  logic              err_c;

  always_comb begin
    int n;
    n     = 0;
    err_c = |is_bad;
    cnt_r = '0;
    av_r  = '0;
    aiv_r = '0;
    sv_r  = '0;
    siv_r = '0;
    for (int k = 0; k < N_ALU; k++) begin
      ao_r[k] = '0;
      ai_r[k] = '0;
    end
    for (int u = 0; u < N_SOLO; u++) begin
      so_r[u] = '0;
      si_r[u] = '0;
    end
    for (int i = 0; i < N_ATOMS; i++) begin
      if (is_alu[i]) begin
        for (int k = 0; k < N_ALU; k++) begin
          if (n == k) begin
            av_r[k]  = 1'b1;
            ao_r[k]  = op_a[i];
            aiv_r[k] = nxt_iv[i];
            ai_r[k]  = nxt_val[i];
          end
        end
        if (n >= N_ALU) err_c = 1'b1;
        n     = n + 1;
        cnt_r = cnt_r + CW'(1);
      end
      for (int u = 0; u < N_SOLO; u++) begin
        if (sel[u][i]) begin
          if (sv_r[u]) begin
            err_c = 1'b1;
          end else begin
            sv_r[u]  = 1'b1;
            so_r[u]  = op_a[i];
            siv_r[u] = nxt_iv[i];
            si_r[u]  = nxt_val[i];
          end
          cnt_r = cnt_r + CW'(1);
        end
      end
    end
  end

  // a rejected molecule issues nothing
  for (genvar k = 0; k < N_ALU; k++) begin : g_alu_pack
    assign alu_v[k]              = av_r[k]  & ~err_c;
    assign alu_iv[k]             = aiv_r[k] & ~err_c;
    assign alu_o[k*OPW +: OPW]   = err_c ? '0 : ao_r[k];
    assign alu_i[k*OPW +: OPW]   = err_c ? '0 : ai_r[k];
  end
  for (genvar u = 0; u < N_SOLO; u++) begin : g_solo_pack
    assign solo_v[u]             = sv_r[u]  & ~err_c;
    assign solo_iv[u]            = siv_r[u] & ~err_c;
    assign solo_o[u*OPW +: OPW]  = err_c ? '0 : so_r[u];
    assign solo_i[u*OPW +: OPW]  = err_c ? '0 : si_r[u];
  end
  assign cnt = err_c ? '0 : cnt_r;
  assign err = err_c;
endmodule

// File: rtl/molecule_dispatch.sv
module molecule_dispatch
  import mdisp_pkg::*;
#(
  parameter  int N_ATOMS = 4,
  parameter  int N_ALU   = 2,
  parameter  int OPW     = 8,
  localparam int CW      = $clog2(N_ATOMS + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_ATOMS-1:0]        atom_vld,
  input  logic [N_ATOMS*TYPE_W-1:0] atom_type,
  input  logic [N_ATOMS*OPW-1:0]    atom_op,
  output logic [N_ALU-1:0]          alu_vld,
  output logic [N_ALU*OPW-1:0]      alu_op,
  output logic [N_ALU-1:0]          alu_imm_vld,
  output logic [N_ALU*OPW-1:0]      alu_imm,
  output logic                      fpu_vld,
  output logic [OPW-1:0]            fpu_op,
  output logic                      fpu_imm_vld,
  output logic [OPW-1:0]            fpu_imm,
  output logic                      lsu_vld,
  output logic [OPW-1:0]            lsu_op,
  output logic                      lsu_imm_vld,
  output logic [OPW-1:0]            lsu_imm,
  output logic                      bru_vld,
  output logic [OPW-1:0]            bru_op,
  output logic                      bru_imm_vld,
  output logic [OPW-1:0]            bru_imm,
  output logic [CW-1:0]             issue_cnt,
  output logic                      bad_mol
);
  logic [N_ATOMS-1:0] is_alu, is_fpu, is_mem, is_br, is_imm, is_bad;

  mdisp_classify #(.N_ATOMS(N_ATOMS)) u_cls (
    .atom_vld (atom_vld),
    .atom_type(atom_type),
    .is_alu   (is_alu),
    .is_fpu   (is_fpu),
    .is_mem   (is_mem),
    .is_br    (is_br),
    .is_imm   (is_imm),
    .is_bad   (is_bad)
  );

  logic [N_ALU-1:0]     n_av, n_aiv;
  logic [N_ALU*OPW-1:0] n_ao, n_ai;
  logic [N_SOLO-1:0]    n_sv, n_siv;
  logic [N_SOLO*OPW-1:0] n_so, n_si;
  logic [CW-1:0]        n_cnt;
  logic                 n_err;

  mdisp_route #(.N_ATOMS(N_ATOMS), .N_ALU(N_ALU), .OPW(OPW), .CW(CW)) u_rte (
    .is_alu (is_alu),
    .is_fpu (is_fpu),
    .is_mem (is_mem),
    .is_br  (is_br),
    .is_imm (is_imm),
    .is_bad (is_bad),
    .atom_op(atom_op),
    .alu_v  (n_av),
    .alu_o  (n_ao),
    .alu_iv (n_aiv),
    .alu_i  (n_ai),
    .solo_v (n_sv),
    .solo_o (n_so),
    .solo_iv(n_siv),
    .solo_i (n_si),
    .cnt    (n_cnt),
    .err    (n_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      alu_vld     <= '0;
      alu_op      <= '0;
      alu_imm_vld <= '0;
      alu_imm     <= '0;
      fpu_vld     <= 1'b0;
      fpu_op      <= '0;
      fpu_imm_vld <= 1'b0;
      fpu_imm     <= '0;
      lsu_vld     <= 1'b0;
      lsu_op      <= '0;
      lsu_imm_vld <= 1'b0;
      lsu_imm     <= '0;
      bru_vld     <= 1'b0;
      bru_op      <= '0;
      bru_imm_vld <= 1'b0;
      bru_imm     <= '0;
      issue_cnt   <= '0;
      bad_mol     <= 1'b0;
    end else begin
      alu_vld     <= n_av;
      alu_op      <= n_ao;
      alu_imm_vld <= n_aiv;
      alu_imm     <= n_ai;
      fpu_vld     <= n_sv[SOLO_FPU];
      fpu_op      <= n_so[SOLO_FPU*OPW +: OPW];
      fpu_imm_vld <= n_siv[SOLO_FPU];
      fpu_imm     <= n_si[SOLO_FPU*OPW +: OPW];
      lsu_vld     <= n_sv[SOLO_MEM];
      lsu_op      <= n_so[SOLO_MEM*OPW +: OPW];
      lsu_imm_vld <= n_siv[SOLO_MEM];
      lsu_imm     <= n_si[SOLO_MEM*OPW +: OPW];
      bru_vld     <= n_sv[SOLO_BR];
      bru_op      <= n_so[SOLO_BR*OPW +: OPW];
      bru_imm_vld <= n_siv[SOLO_BR];
      bru_imm     <= n_si[SOLO_BR*OPW +: OPW];
      issue_cnt   <= n_cnt;
      bad_mol     <= n_err;
    end
  end
endmodule

// File: rtl/molecule_dispatch_chk.sv
module molecule_dispatch_chk
  import mdisp_pkg::*;
#(
  parameter  int N_ATOMS = 4,
  parameter  int N_ALU   = 2,
  parameter  int OPW     = 8,
  localparam int CW      = $clog2(N_ATOMS + 1)
) (
  input logic                      clk,
  input logic                      rst,
  input logic [N_ATOMS-1:0]        atom_vld,
  input logic [N_ATOMS*TYPE_W-1:0] atom_type,
  input logic [N_ATOMS*OPW-1:0]    atom_op,
  input logic [N_ALU-1:0]          alu_vld,
  input logic [N_ALU*OPW-1:0]      alu_op,
  input logic [N_ALU-1:0]          alu_imm_vld,
  input logic [N_ALU*OPW-1:0]      alu_imm,
  input logic                      fpu_vld,
  input logic [OPW-1:0]            fpu_op,
  input logic                      fpu_imm_vld,
  input logic [OPW-1:0]            fpu_imm,
  input logic                      lsu_vld,
  input logic [OPW-1:0]            lsu_op,
  input logic                      lsu_imm_vld,
  input logic [OPW-1:0]            lsu_imm,
  input logic                      bru_vld,
  input logic [OPW-1:0]            bru_op,
  input logic                      bru_imm_vld,
  input logic [OPW-1:0]            bru_imm,
  input logic [CW-1:0]             issue_cnt,
  input logic                      bad_mol
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (issue_cnt == '0 && !bad_mol && alu_vld == '0 && !fpu_vld && !lsu_vld && !bru_vld));

  // R1
  empty_in_chk: assert property (@(posedge clk) disable iff (rst)
    (atom_vld == '0) |=> (issue_cnt == '0 && !bad_mol));

  // R3
  alu_fill_chk: assert property (@(posedge clk) disable iff (rst)
    ((alu_vld + N_ALU'(1)) & alu_vld) == '0);

  // R5
  imm_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_imm_vld & ~alu_vld) == '0 && (!fpu_imm_vld || fpu_vld) &&
    (!lsu_imm_vld || lsu_vld) && (!bru_imm_vld || bru_vld));

  // R7
  bad_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bad_mol |-> (issue_cnt == '0 && alu_vld == '0 && alu_imm_vld == '0 &&
                 !fpu_vld && !lsu_vld && !bru_vld));

  // R8
  count_match_chk: assert property (@(posedge clk) disable iff (rst)
    32'(issue_cnt) == $countones({alu_vld, fpu_vld, lsu_vld, bru_vld}));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (fpu_vld || fpu_op == '0) && (lsu_vld || lsu_op == '0) &&
    (bru_vld || bru_op == '0) && (fpu_imm_vld || fpu_imm == '0) &&
    (lsu_imm_vld || lsu_imm == '0) && (bru_imm_vld || bru_imm == '0));
endmodule

bind molecule_dispatch molecule_dispatch_chk #(
  .N_ATOMS(N_ATOMS), .N_ALU(N_ALU), .OPW(OPW)
) u_chk (.*);

// File: tb/molecule_dispatch_test.sv
`timescale 1ns/1ps
module molecule_dispatch_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [3:0]  av;
  logic [11:0] at;
  logic [31:0] ao;
  logic [1:0]  alu_vld, alu_imm_vld;
  logic [15:0] alu_op, alu_imm;
  logic        fpu_vld, fpu_imm_vld, lsu_vld, lsu_imm_vld, bru_vld, bru_imm_vld;
  logic [7:0]  fpu_op, fpu_imm, lsu_op, lsu_imm, bru_op, bru_imm;
  logic [2:0]  issue_cnt;
  logic        bad_mol;

  molecule_dispatch uut (
    .clk(clk), .rst(rst), .atom_vld(av), .atom_type(at), .atom_op(ao),
    .alu_vld(alu_vld), .alu_op(alu_op), .alu_imm_vld(alu_imm_vld), .alu_imm(alu_imm),
    .fpu_vld(fpu_vld), .fpu_op(fpu_op), .fpu_imm_vld(fpu_imm_vld), .fpu_imm(fpu_imm),
    .lsu_vld(lsu_vld), .lsu_op(lsu_op), .lsu_imm_vld(lsu_imm_vld), .lsu_imm(lsu_imm),
    .bru_vld(bru_vld), .bru_op(bru_op), .bru_imm_vld(bru_imm_vld), .bru_imm(bru_imm),
    .issue_cnt(issue_cnt), .bad_mol(bad_mol)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // expected outputs, computed from the requirements
  logic [1:0]  e_av, e_aiv;
  logic [15:0] e_ao, e_ai;
  logic [2:0]  e_sv, e_siv;   // 0 FP, 1 load/store, 2 branch
  logic [7:0]  e_so [3];
  logic [7:0]  e_si [3];
  int          e_cnt;
  bit          e_bad;

  task automatic model();
    int nalu;
    int owner [4];
    nalu = 0; e_av = 0; e_aiv = 0; e_ao = 0; e_ai = 0; e_sv = 0; e_siv = 0;
    e_cnt = 0; e_bad = 0;
    for (int u = 0; u < 3; u++) begin e_so[u] = 0; e_si[u] = 0; end
    for (int i = 0; i < 4; i++) begin
      logic [2:0] t;
      logic [7:0] o;
      owner[i] = -1;
      t = at[i*3 +: 3];
      o = ao[i*8 +: 8];
      if (av[i]) begin
        if (t == 3'd0) begin
          if (nalu < 2) begin
            e_av[nalu] = 1'b1; e_ao[nalu*8 +: 8] = o; owner[i] = nalu;
          end else e_bad = 1;
          nalu++; e_cnt++;
        end else if (t >= 3'd1 && t <= 3'd3) begin
          int u;
          u = int'(t) - 1;
          if (e_sv[u]) e_bad = 1;
          else begin e_sv[u] = 1'b1; e_so[u] = o; owner[i] = 2 + u; end
          e_cnt++;
        end else if (t == 3'd4) begin
          if (i == 0 || !av[i-1] || at[(i-1)*3 +: 3] == 3'd4) e_bad = 1;
          else if (owner[i-1] == 0 || owner[i-1] == 1) begin
            e_aiv[owner[i-1]] = 1'b1; e_ai[owner[i-1]*8 +: 8] = o;
          end else if (owner[i-1] >= 2) begin
            e_siv[owner[i-1]-2] = 1'b1; e_si[owner[i-1]-2] = o;
          end
        end else e_bad = 1;
      end
    end
    if (e_bad) begin
      e_av = 0; e_aiv = 0; e_ao = 0; e_ai = 0; e_sv = 0; e_siv = 0; e_cnt = 0;
      for (int u = 0; u < 3; u++) begin e_so[u] = 0; e_si[u] = 0; end
    end
  endtask

  task automatic compare_all();
    chk("R2 R3 R4 R6 bad flag", 64'(bad_mol), 64'(e_bad));
    chk("R8 issue count", 64'(issue_cnt), 64'(e_cnt));
    chk(e_bad ? "R7 alu" : "R3 R9 alu", 64'({alu_vld, alu_op}), 64'({e_av, e_ao}));
    chk(e_bad ? "R7 alu imm" : "R5 R9 alu imm", 64'({alu_imm_vld, alu_imm}), 64'({e_aiv, e_ai}));
    chk(e_bad ? "R7 fpu" : "R4 R5 R9 fpu", 64'({fpu_vld, fpu_op, fpu_imm_vld, fpu_imm}),
        64'({e_sv[0], e_so[0], e_siv[0], e_si[0]}));
    chk(e_bad ? "R7 lsu" : "R4 R5 R9 lsu", 64'({lsu_vld, lsu_op, lsu_imm_vld, lsu_imm}),
        64'({e_sv[1], e_so[1], e_siv[1], e_si[1]}));
    chk(e_bad ? "R7 bru" : "R4 R5 R9 bru", 64'({bru_vld, bru_op, bru_imm_vld, bru_imm}),
        64'({e_sv[2], e_so[2], e_siv[2], e_si[2]}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    av = 0; at = 0; ao = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset count", 64'(issue_cnt), 0);
    chk("R1 reset flag", 64'(bad_mol), 0);
    chk("R1 reset valids", 64'({alu_vld, fpu_vld, lsu_vld, bru_vld}), 0);
    rst = 0;
    @(negedge clk);
    // R1 latency: ALU, ALU, FP, load/store
    av = 4'hF; at = {3'd2, 3'd1, 3'd0, 3'd0}; ao = 32'h44332211;
    #1 chk("R1 no early issue", 64'(issue_cnt), 0);
    @(negedge clk);
    chk("R1 one-cycle issue", 64'(issue_cnt), 4);
    chk("R3 alu pair", 64'({alu_vld, alu_op}), 64'({2'b11, 16'h2211}));
    // R1 synchronous reset with a live molecule
    rst = 1;
    @(negedge clk);
    chk("R1 reset mid-run", 64'({issue_cnt, alu_vld, fpu_vld, lsu_vld}), 0);
    rst = 0;
    av = 0;
    @(negedge clk);
    // exhaustive sweep: each slot invalid or one of 8 type codes
    for (int idx = 0; idx < 6561; idx++) begin
      int pw;
      if (idx > 0) compare_all();
      pw = 1;
      for (int i = 0; i < 4; i++) begin
        int d;
        d = (idx / pw) % 9;
        pw = pw * 9;
        av[i] = (d != 0);
        at[i*3 +: 3] = (d == 0) ? 3'((idx + i) % 8) : 3'(d - 1);
        ao[i*8 +: 8] = 8'((idx * 7 + i * 53 + 1) % 256);
      end
      model();
      @(negedge clk);
    end
    compare_all();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule